// File: doc/BRIEF.md
# Atrial Tachycardia Mode-Switch Detector

This block decides whether a dual-chamber pacing controller should keep tracking the atrium or fall back to ventricular-only pacing. It looks only at atrial events that the refractory logic has already passed: plain atrial senses and senses that land in the post-ventricular atrial refractory window. Blanked events never reach it. Each interval between two such events is measured in timer ticks and graded as fast or slow. A saturating up/down score counts fast intervals up and slow intervals down.

When the score reaches an entry threshold, the block opens a confirmation window that is measured in ventricular events, and scoring continues during that window. If the score is still positive when the window closes, the block raises the fallback mode level and emits a one-cycle pulse. In fallback, the surrounding timers switch off the atrioventricular delay and take ventricular pacing from the lower-rate timer. When the score falls to zero, any open window is abandoned. If the block is in fallback at that moment, it returns to dual-chamber mode with a one-cycle return pulse.

The pacing timers themselves sit outside this block. It supplies only the mode level and the two transition pulses.

Top module: `atrial_mode_switch`

## Requirements
- R1: Either atrial input (`atr_sense` or `atr_refr`) counts as one atrial event. Both inputs high in the same cycle count as a single event.
- R2: The interval is the number of `tick` cycles between two atrial events. It is fast when below `TRIG_TICKS` (default 350, so 349 is fast and 350 is slow), and slow otherwise.
- R3: The first atrial event after reset only starts interval timing and does not change the score.
- R4: The score rises by one per fast interval and falls by one per slow interval. It saturates at 0 and at `CNT_MAX` (default 15).
- R5: In dual-chamber mode, a score at or above `ENTRY_CNT` (default 8) opens a confirmation window. Fallback does not occur before `DUR_VEVTS` (default 8) ventricular events have been seen inside that window.
- R6: On the final ventricular event of the window, with a positive score, `fallback` goes to 1 and `to_fallback` pulses for exactly one cycle.
- R7: A score of zero during the confirmation window abandons the window. The mode stays dual-chamber and no pulse is produced.
- R8: A score of zero in fallback returns `fallback` to 0, and `to_dual` pulses for exactly one cycle.
- R9: After reset, `fallback`, `to_fallback` and `to_dual` are all 0.
- R10: Ventricular events outside an open confirmation window have no effect on the mode.
- R11: A mode change shows on the outputs within four clock cycles of the event that causes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle time-base strobe (1 ms nominal) |
| atr_sense | input | 1 | Atrial sense outside blanking, one-cycle pulse |
| atr_refr | input | 1 | Atrial refractory sense outside blanking, one-cycle pulse |
| vent_evt | input | 1 | Ventricular sense or pace, one-cycle pulse |
| fallback | output | 1 | Mode level: 0 dual-chamber, 1 ventricular-only |
| to_fallback | output | 1 | One-cycle pulse on entering fallback |
| to_dual | output | 1 | One-cycle pulse on returning to dual-chamber |

## Verification
The hardest states to reach are two score limits. One is an upper saturation long enough that exactly fifteen slow intervals are needed to leave fallback. The other is a window abandoned by the score falling to zero between ventricular events. Directed runs build both on purpose: twenty fast intervals fill the score, and slow intervals are placed inside a half-finished window. Interval timing is exact because the bench holds `tick` high for a chosen number of cycles before each atrial pulse. This allows the 349/350 boundary to be hit directly. A seeded random phase then alternates fast and slow runs with scattered ventricular events, and a bench model of the score and window predicts the mode and the pulse counts.

// File: rtl/atrial_mode_switch_pkg.sv
package atrial_mode_switch_pkg;
   typedef enum logic [1:0] {
      MS_DUAL     = 2'd0,
      MS_CONFIRM  = 2'd1,
      MS_FALLBACK = 2'd2
   } ms_state_e;
endpackage

// File: rtl/atr_interval_meter.sv
module atr_interval_meter #(
   parameter int TRIG_TICKS = 350
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic atr_evt,
   output logic fast_p,
   output logic slow_p
);
   localparam int SW = $clog2(TRIG_TICKS + 1);
   localparam logic [SW-1:0] TRIG_V = SW'(TRIG_TICKS);

   logic [SW-1:0] since_q;
   logic          have_ref_q;

   // elapsed time saturates at the threshold: anything longer is slow anyway
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_q    <= '0;
         have_ref_q <= 1'b0;
         fast_p     <= 1'b0;
         slow_p     <= 1'b0;
      end else begin
         fast_p <= 1'b0;
         slow_p <= 1'b0;
         if (atr_evt) begin
            if (have_ref_q) begin
               if (since_q < TRIG_V) fast_p <= 1'b1;
               else                  slow_p <= 1'b1;
            end
            have_ref_q <= 1'b1;
            since_q    <= '0;
         end else if (tick && (since_q != TRIG_V)) begin
            since_q <= since_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tachy_score.sv
module tachy_score #(
   parameter int CNT_MAX = 15,
   localparam int CW = $clog2(CNT_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] MAX_V = CW'(CNT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (inc && !dec) begin
         if (cnt != MAX_V) cnt <= cnt + 1'b1;
      end else if (dec && !inc) begin
         if (cnt != '0) cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/mode_switch_fsm.sv
module mode_switch_fsm
   import atrial_mode_switch_pkg::*;
#(
   parameter int CW        = 4,
   parameter int ENTRY_CNT = 8,
   parameter int DUR_VEVTS = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cnt,
   input  logic          vent_evt,
   output logic          fallback,
   output logic          to_fallback,
   output logic          to_dual
);
   localparam int DW = $clog2(DUR_VEVTS + 1);
   localparam logic [CW-1:0] ENTRY_V = CW'(ENTRY_CNT);
   localparam logic [DW-1:0] LAST_V  = DW'(DUR_VEVTS - 1);

   ms_state_e     st_q;
   logic [DW-1:0] dur_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= MS_DUAL;
         dur_q       <= '0;
         to_fallback <= 1'b0;
         to_dual     <= 1'b0;
      end else begin
         to_fallback <= 1'b0;
         to_dual     <= 1'b0;
         case (st_q)
            MS_DUAL: begin
               if (cnt >= ENTRY_V) begin
                  st_q  <= MS_CONFIRM;
                  dur_q <= '0;
               end
            end
            MS_CONFIRM: begin
               if (cnt == '0) begin
                  st_q <= MS_DUAL;
               end else if (vent_evt) begin
                  if (dur_q == LAST_V) begin
                     st_q        <= MS_FALLBACK;
                     to_fallback <= 1'b1;
                  end else begin
                     dur_q <= dur_q + 1'b1;
                  end
               end
            end
            MS_FALLBACK: begin
               if (cnt == '0) begin
                  st_q    <= MS_DUAL;
                  to_dual <= 1'b1;
               end
            end
            default: st_q <= MS_DUAL;
         endcase
      end
   end

   assign fallback = (st_q == MS_FALLBACK);
endmodule

// File: rtl/atrial_mode_switch.sv
module atrial_mode_switch #(
   parameter int TRIG_TICKS = 350,
   parameter int CNT_MAX    = 15,
   parameter int ENTRY_CNT  = 8,
   parameter int DUR_VEVTS  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic atr_sense,
   input  logic atr_refr,
   input  logic vent_evt,
   output logic fallback,
   output logic to_fallback,
   output logic to_dual
);
   localparam int CW = $clog2(CNT_MAX + 1);

   if (TRIG_TICKS < 2) begin : g_bad_trig
      $error("TRIG_TICKS must be at least 2");
   end
   if (ENTRY_CNT < 1 || ENTRY_CNT > CNT_MAX) begin : g_bad_entry
      $error("ENTRY_CNT must lie in 1..CNT_MAX");
   end
   if (DUR_VEVTS < 1) begin : g_bad_dur
      $error("DUR_VEVTS must be at least 1");
   end

   logic          fast_p, slow_p;
   logic [CW-1:0] cnt_q;

   atr_interval_meter #(.TRIG_TICKS(TRIG_TICKS)) u_meter (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .atr_evt(atr_sense | atr_refr),
      .fast_p(fast_p), .slow_p(slow_p)
   );

   tachy_score #(.CNT_MAX(CNT_MAX)) u_score (
      .clk(clk), .rst_n(rst_n), .inc(fast_p), .dec(slow_p), .cnt(cnt_q)
   );

   mode_switch_fsm #(.CW(CW), .ENTRY_CNT(ENTRY_CNT), .DUR_VEVTS(DUR_VEVTS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .vent_evt(vent_evt),
      .fallback(fallback), .to_fallback(to_fallback), .to_dual(to_dual)
   );
endmodule

// File: rtl/atrial_mode_switch_chk.sv
module atrial_mode_switch_chk #(
   parameter int CW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [CW-1:0] cnt,
   input logic          fallback,
   input logic          to_fb,
   input logic          to_dual
);
   a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt + 1'b1 == $past(cnt)));

   a_r6_rise_pulses: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fallback) |-> to_fb);

   a_r6_pulse_level: assert property (@(posedge clk) disable iff (!rst_n)
      to_fb |-> fallback);

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      to_fb |=> !to_fb);

   a_r7_entry_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      to_fb |-> ($past(cnt) != '0));

   a_r8_fall_pulses: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fallback) |-> (to_dual && ($past(cnt) == '0)));

   a_r8_pulse_level: assert property (@(posedge clk) disable iff (!rst_n)
      to_dual |-> !fallback);

   a_r9_excl_pulses: assert property (@(posedge clk) disable iff (!rst_n)
      !(to_fb && to_dual));
endmodule

bind atrial_mode_switch atrial_mode_switch_chk #(.CW($clog2(CNT_MAX + 1))) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .fallback(fallback),
   .to_fb(to_fallback), .to_dual(to_dual)
);

// File: tb/atrial_mode_switch_test.sv
module atrial_mode_switch_test;
   localparam int TRIG = 350, MAXC = 15, ENTRY = 8, DUR = 8;

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
   logic atr_sense = 1'b0, atr_refr = 1'b0, vent_evt = 1'b0;
   logic fallback, to_fallback, to_dual;

   int n_checks = 0, n_fail = 0;
   int seen_fb = 0, seen_dual = 0;
   // bench model
   int m_cnt = 0, m_st = 0, m_dur = 0, exp_fb = 0, exp_dual = 0;
   bit m_ref = 0;

   always #10 clk = ~clk;

   atrial_mode_switch uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .atr_sense(atr_sense),
      .atr_refr(atr_refr), .vent_evt(vent_evt), .fallback(fallback),
      .to_fallback(to_fallback), .to_dual(to_dual)
   );

   always @(negedge clk) begin
      if (to_fallback) seen_fb++;
      if (to_dual) seen_dual++;
   end

   function automatic bit is_fast(int gap);
      return gap < TRIG;
   endfunction

   function automatic int sat(int v);
      return (v < 0) ? 0 : ((v > MAXC) ? MAXC : v);
   endfunction

   task automatic check(string tag);
      int efb;
      efb = (m_st == 2) ? 1 : 0;
      n_checks++;
      if (fallback !== efb[0] || seen_fb != exp_fb || seen_dual != exp_dual) begin
         n_fail++;
         $display("FAIL %s: fallback=%0b/to_fb#=%0d/to_dual#=%0d expected %0d/%0d/%0d",
                  tag, fallback, seen_fb, seen_dual, efb, exp_fb, exp_dual);
      end
   endtask

   // kind: 0 sense, 1 refractory sense, 2 both at once (R1)
   task automatic atrial(int gap, int kind, string tag);
      repeat (gap) @(negedge clk) tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      atr_sense = (kind != 1);
      atr_refr  = (kind != 0);
      @(negedge clk);
      atr_sense = 1'b0;
      atr_refr  = 1'b0;
      repeat (4) @(negedge clk);
      if (m_ref) m_cnt = sat(is_fast(gap) ? m_cnt + 1 : m_cnt - 1);
      m_ref = 1;
      if (m_st == 1 && m_cnt == 0) m_st = 0;
      else if (m_st == 2 && m_cnt == 0) begin m_st = 0; exp_dual++; end
      else if (m_st == 0 && m_cnt >= ENTRY) begin m_st = 1; m_dur = 0; end
      check(tag);
   endtask

   task automatic vent(string tag);
      @(negedge clk) vent_evt = 1'b1;
      @(negedge clk) vent_evt = 1'b0;
      repeat (3) @(negedge clk);
      if (m_st == 1) begin
         m_dur++;
         if (m_dur == DUR) begin m_st = 2; exp_fb++; end
      end
      check(tag);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset state");
      if (to_fallback !== 1'b0 || to_dual !== 1'b0) begin
         n_fail++;
         $display("FAIL R9: pulses %0b%0b expected 00", to_fallback, to_dual);
      end
      n_checks++;

      // R3: first event only records; 8 fast events give a score of 7
      for (int i = 0; i < 8; i++) atrial(200, i % 3, "R3 first event unclassified");
      for (int i = 0; i < 8; i++) vent("R10 vent in dual ignored");
      atrial(200, 0, "R5 entry reached");
      for (int i = 0; i < 7; i++) vent("R5 window not yet over");
      vent("R6 fallback at end of window");
      for (int i = 0; i < 7; i++) atrial(500, 1, "R8 score still positive");
      atrial(500, 0, "R8 return to dual");

      // R2 boundary: 349 is fast, 350 is slow
      for (int i = 0; i < 8; i++) atrial(349, 2, "R2 349 ticks fast");
      for (int i = 0; i < 8; i++) vent("R2 R6 fallback after 349 run");
      for (int i = 0; i < 8; i++) atrial(350, 1, "R2 350 ticks slow");

      // R7 abort inside the window
      for (int i = 0; i < 8; i++) atrial(250, 0, "R7 build entry");
      for (int i = 0; i < 3; i++) vent("R7 partial window");
      for (int i = 0; i < 8; i++) atrial(600, 0, "R7 score to zero");
      for (int i = 0; i < 8; i++) vent("R7 abandoned window, no fallback");

      // R4 upper saturation
      for (int i = 0; i < 20; i++) atrial(180, 1, "R4 fill score");
      for (int i = 0; i < 8; i++) vent("R4 R6 fallback");
      for (int i = 0; i < 15; i++) atrial(700, 0, "R4 R8 fifteen slow to exit");
      // R4 lower saturation
      for (int i = 0; i < 5; i++) atrial(700, 0, "R4 floor at zero");
      for (int i = 0; i < 7; i++) atrial(200, 2, "R4 climb from floor");
      for (int i = 0; i < 8; i++) vent("R4 R11 seven fast stays dual");

      // random phase
      begin
         bit fast_phase = 1'b1;
         for (int s = 0; s < 220; s++) begin
            int r = $urandom % 10;
            if ($urandom % 25 == 0) fast_phase = ~fast_phase;
            if (r < 4) vent("R5 R6 R10 R11 random vent");
            else begin
               int gap = fast_phase ? 150 + ($urandom % 200) : 350 + ($urandom % 300);
               if ($urandom % 8 == 0) gap = fast_phase ? 400 : 200;
               atrial(gap, $urandom % 3, "R1 R2 R4 R7 R8 R11 random atrial");
            end
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule